// File: doc/BRIEF.md
# Dataway Request/Grant Chain Arbiter

This block decides who owns a shared crate dataway when this controller and one or more auxiliary controllers all compete for it. Priority is positional: a grant signal enters the controller (`gi_in`) and is passed on to the next controller down the chain (`go_out`) only while this controller has no interest in the bus. Two bussed lines complete the scheme. A request line (`rq_out`) tells the other controllers that a controller is asking for the bus. An inhibit line (`ri_out` driven, `ri_in` sensed from the others) marks the bus as taken. Both are modelled as active-high levels with separate drive and sense pins. The wired-OR electrical side is left to the pads.

The local sequencer raises `loc_req` and waits for `loc_gnt`. It then runs its dataway cycle and pulses `loc_done` when the cycle ends. Each serial command carries a lockout flag, which is presented through `cmd_valid`/`cmd_lock`. When the flag is set, the inhibit line is kept after the cycle and the downstream grant stays withheld, so auxiliary controllers cannot get in. While the bus is held this way, a further local request is granted at once. The hold ends when a command arrives with the flag clear, or when a watchdog of `LOCK_TICKS` clocks expires. The default of 250000 clocks is 5 ms at 50 MHz.

No data moves through this block. Every pin is a plain level or single-cycle strobe, so there is no valid/ready handshake and no back-pressure.

Top module: `dw_chain_arbiter`

## Requirements
- R1: After reset the block is idle: `rq_out`, `ri_out` and `loc_gnt` are 0, and the lockout flag is clear.
- R2: While idle, `go_out` equals `gi_in` in the same cycle, and `rq_out`, `ri_out` and `loc_gnt` stay 0.
- R3: Idle with `loc_req`=1 and `ri_in`=0 moves to waiting on the next clock. While waiting, `go_out`=0 and `rq_out` = NOT `ri_in`. Idle with `loc_req`=1 but `ri_in`=1 stays idle.
- R4: Waiting with `loc_req`=1, `gi_in`=1 and `ri_in`=0 moves to owning on the next clock: `ri_out`=1, `rq_out`=0, `loc_gnt`=1, `go_out`=0.
- R5: Owning lasts until `loc_done`=1 is sampled. During that time `ri_out` and `loc_gnt` stay 1 and `go_out` stays 0.
- R6: `loc_done` while owning with the lockout flag clear returns the block to idle on the next clock.
- R7: `loc_done` while owning with the lockout flag set moves the block to holding on the next clock: `ri_out`=1, `loc_gnt`=0, `go_out`=0, `rq_out`=0.
- R8: A `cmd_valid` strobe loads the lockout flag from `cmd_lock`. A strobe with `cmd_lock`=0 while holding returns the block to idle on the next clock.
- R9: With no command arriving, holding lasts exactly `LOCK_TICKS` cycles, then the block goes idle and the flag clears. A strobe with `cmd_lock`=1 while holding restarts the count.
- R10: If `loc_req` drops while waiting, the block returns to idle on the next clock without ever driving `ri_out`.
- R11: A `loc_req` while holding, with no release in the same cycle, moves straight to owning on the next clock, without driving `rq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_req | input | 1 | Local sequencer wants the dataway |
| loc_done | input | 1 | Local dataway cycle finished (strobe) |
| cmd_valid | input | 1 | A new command's lockout flag is present (strobe) |
| cmd_lock | input | 1 | Lockout flag of that command |
| gi_in | input | 1 | Grant arriving from the upstream controller |
| ri_in | input | 1 | Inhibit driven by other controllers |
| rq_out | output | 1 | Drive for the bussed request line |
| ri_out | output | 1 | Drive for the bussed inhibit line |
| go_out | output | 1 | Grant passed to the downstream controller |
| loc_gnt | output | 1 | Dataway granted to the local sequencer |

## Verification
A wrong state register shows at the pins in the cycle right after the bad transition, because all four outputs decode directly from the state. An idle block that thinks it holds the bus stops passing `gi_in` to `go_out`. A block stuck waiting keeps `rq_out` high. A block that leaves holding too early or too late differs from the expected inhibit level in exactly the cycle after `LOCK_TICKS` has run out. A lockout flag loaded wrongly stays hidden until the next `loc_done`, so the bench compares every cycle against an independent model, over long random runs that include back-to-back locked cycles.

// File: rtl/dwarb_pkg.sv
package dwarb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_WAIT = 2'd1,
    ARB_OWN  = 2'd2,
    ARB_HOLD = 2'd3
  } arb_state_e;
endpackage

// File: rtl/dwarb_lock_keeper.sv
module dwarb_lock_keeper #(
  parameter int LOCK_TICKS = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_lock,
  input  logic in_hold,
  output logic lock_q,
  output logic hold_release
);
  localparam int CW = $clog2(LOCK_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_TICKS - 1);

  logic [CW-1:0] tick_q;
  logic          keep_cmd, drop_cmd, expire;

  assign keep_cmd     = cmd_valid && cmd_lock;
  assign drop_cmd     = cmd_valid && !cmd_lock;
  assign expire       = in_hold && (tick_q == LAST) && !keep_cmd;
  assign hold_release = drop_cmd || expire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else if (!in_hold || keep_cmd || expire) begin
      tick_q <= '0;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         lock_q <= 1'b0;
    else if (cmd_valid) lock_q <= cmd_lock;
    else if (expire)    lock_q <= 1'b0;
  end

  // R9
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q < CW'(LOCK_TICKS));
  // R8
  unlock_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cmd |=> !lock_q);
  // R8
  lock_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keep_cmd |=> lock_q);
endmodule

// File: rtl/dwarb_chain_fsm.sv
module dwarb_chain_fsm
  import dwarb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loc_req,
  input  logic       loc_done,
  input  logic       gi_in,
  input  logic       ri_in,
  input  logic       lock_q,
  input  logic       hold_release,
  output arb_state_e state
);
  arb_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ARB_IDLE: if (loc_req && !ri_in) nxt = ARB_WAIT;
      ARB_WAIT: begin
        if (!loc_req)                nxt = ARB_IDLE;
        else if (gi_in && !ri_in)    nxt = ARB_OWN;
      end
      ARB_OWN:  if (loc_done) nxt = lock_q ? ARB_HOLD : ARB_IDLE;
      ARB_HOLD: begin
        if (hold_release) nxt = ARB_IDLE;
        else if (loc_req) nxt = ARB_OWN;
      end
      default: nxt = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ARB_IDLE;
    else        state <= nxt;
  end

  // R4
  take_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ARB_WAIT && loc_req && gi_in && !ri_in) |=> state == ARB_OWN);
  // R10
  withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ARB_WAIT && !loc_req) |=> state == ARB_IDLE);
  // R11
  relock_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ARB_HOLD && loc_req && !hold_release) |=> state == ARB_OWN);
  // R5
  own_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ARB_OWN && !loc_done) |=> state == ARB_OWN);
endmodule

// File: rtl/dwarb_pin_drive.sv
module dwarb_pin_drive
  import dwarb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  arb_state_e state,
  input  logic       gi_in,
  input  logic       ri_in,
  output logic       rq_out,
  output logic       ri_out,
  output logic       go_out,
  output logic       loc_gnt
);
  always_comb begin
    rq_out  = 1'b0;
    ri_out  = 1'b0;
    go_out  = 1'b0;
    loc_gnt = 1'b0;
    unique case (state)
      ARB_IDLE: go_out = gi_in;
      ARB_WAIT: rq_out = !ri_in;
      ARB_OWN: begin
        ri_out  = 1'b1;
        loc_gnt = 1'b1;
      end
      ARB_HOLD: ri_out = 1'b1;
      default: ;
    endcase
  end

  // R3
  go_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_out |-> (!rq_out && !ri_out && !loc_gnt));
  // R4
  rq_ri_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rq_out && ri_out));
  // R5
  gnt_needs_ri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_gnt |-> ri_out);
  // R4
  ri_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri_out) |-> ($past(gi_in) && !$past(ri_in)));
endmodule

// File: rtl/dw_chain_arbiter.sv
module dw_chain_arbiter
  import dwarb_pkg::*;
#(
  parameter int LOCK_TICKS = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loc_req,
  input  logic loc_done,
  input  logic cmd_valid,
  input  logic cmd_lock,
  input  logic gi_in,
  input  logic ri_in,
  output logic rq_out,
  output logic ri_out,
  output logic go_out,
  output logic loc_gnt
);
  arb_state_e state;
  logic       lock_q, hold_release;

  dwarb_lock_keeper #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_lock(cmd_lock),
    .in_hold(state == ARB_HOLD), .lock_q(lock_q), .hold_release(hold_release)
  );

  dwarb_chain_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .loc_req(loc_req), .loc_done(loc_done),
    .gi_in(gi_in), .ri_in(ri_in), .lock_q(lock_q),
    .hold_release(hold_release), .state(state)
  );

  dwarb_pin_drive u_pins (
    .clk(clk), .rst_n(rst_n), .state(state), .gi_in(gi_in), .ri_in(ri_in),
    .rq_out(rq_out), .ri_out(ri_out), .go_out(go_out), .loc_gnt(loc_gnt)
  );
endmodule

// File: tb/tb_dw_chain_arbiter.sv
module tb_dw_chain_arbiter;
  localparam int LT = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic loc_req = 0, loc_done = 0, cmd_valid = 0, cmd_lock = 0, gi_in = 0, ri_in = 0;
  logic rq_out, ri_out, go_out, loc_gnt;

  int vectors = 0, miscompares = 0;
  string cur_tag = "";
  // model state: 0 idle, 1 waiting, 2 owning, 3 holding
  int m_st = 0, m_cnt = 0;
  bit m_lock = 0;

  dw_chain_arbiter #(.LOCK_TICKS(LT)) dut (
    .clk(clk), .rst_n(rst_n), .loc_req(loc_req), .loc_done(loc_done),
    .cmd_valid(cmd_valid), .cmd_lock(cmd_lock), .gi_in(gi_in), .ri_in(ri_in),
    .rq_out(rq_out), .ri_out(ri_out), .go_out(go_out), .loc_gnt(loc_gnt)
  );

  always #10 clk = ~clk;

  function automatic logic [3:0] expect_pins(int st, bit gi, bit ri);
    // {rq, ri, go, gnt}
    case (st)
      0: return {1'b0, 1'b0, gi, 1'b0};
      1: return {~ri, 1'b0, 1'b0, 1'b0};
      2: return 4'b0101;
      default: return 4'b0100;
    endcase
  endfunction

  function automatic string state_tag(int st);
    case (st)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check_pins(string tag);
    logic [3:0] exp_v, act_v;
    exp_v = expect_pins(m_st, gi_in, ri_in);
    act_v = {rq_out, ri_out, go_out, loc_gnt};
    vectors++;
    if (act_v !== exp_v) begin
      miscompares++;
      $display("FAIL %s t=%0t {rq,ri,go,gnt} actual=%b expected=%b", tag, $time, act_v, exp_v);
    end
  endtask

  task automatic model_step(bit req, bit done, bit cv, bit cl, bit gi, bit ri);
    bit expire;
    int nst;
    expire = (m_st == 3) && (m_cnt == LT - 1) && !(cv && cl);
    nst = m_st;
    case (m_st)
      0: if (req && !ri) nst = 1;
      1: if (!req) nst = 0; else if (gi && !ri) nst = 2;
      2: if (done) nst = m_lock ? 3 : 0;
      default: if (expire || (cv && !cl)) nst = 0; else if (req) nst = 2;
    endcase
    if (m_st != 3 || (cv && cl) || expire) m_cnt = 0; else m_cnt++;
    if (cv) m_lock = cl; else if (expire) m_lock = 0;
    m_st = nst;
  endtask

  task automatic cyc(bit req, bit done, bit cv, bit cl, bit gi, bit ri);
    @(negedge clk);
    loc_req = req; loc_done = done; cmd_valid = cv; cmd_lock = cl; gi_in = gi; ri_in = ri;
    #2;
    check_pins(cur_tag == "" ? state_tag(m_st) : cur_tag);
    @(posedge clk);
    model_step(req, done, cv, cl, gi, ri);
  endtask

  initial begin : watchdog
    #3000000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    bit req_h;
    void'($urandom(32'h5eed_a11b));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state with grant coming in
    cur_tag = "R1"; cyc(0, 0, 0, 0, 1, 0);
    cur_tag = "R2"; cyc(0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 1, 1);
    // R3: request blocked by foreign inhibit, then accepted, rq tracks ri_in
    cur_tag = "R3"; cyc(1, 0, 0, 0, 1, 1); cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 1); cyc(1, 0, 0, 0, 1, 1);
    // R4: grant arrives
    cur_tag = "R4"; cyc(1, 0, 0, 0, 1, 0); cyc(1, 0, 0, 0, 0, 0);
    cur_tag = "R5"; cyc(1, 0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1, 0);
    // R6: done without lock
    cur_tag = "R6"; cyc(0, 1, 0, 0, 1, 0); cyc(0, 0, 0, 0, 1, 0);
    // R10: withdraw while waiting
    cur_tag = "R10"; cyc(1, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 1, 0);
    // R7/R8: locked cycle, then unlock command
    cur_tag = "R8"; cyc(0, 0, 1, 1, 0, 0);
    cur_tag = "R7"; cyc(1, 0, 0, 0, 0, 0); cyc(1, 0, 0, 0, 1, 0);
    cyc(0, 1, 0, 0, 1, 0); cyc(0, 0, 0, 0, 1, 0);
    cur_tag = "R8"; cyc(0, 0, 1, 0, 1, 0); cyc(0, 0, 0, 0, 1, 0);
    // R11: regrant while holding; R9: watchdog with one restart
    cur_tag = "R9"; cyc(0, 0, 1, 1, 0, 0); cyc(1, 0, 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 1, 0); cyc(0, 1, 0, 0, 1, 0);
    cur_tag = "R11"; cyc(1, 0, 0, 0, 1, 0); cyc(0, 1, 0, 0, 1, 0);
    cur_tag = "R9";
    for (int i = 0; i < LT / 2; i++) cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 1, 1, 1, 0);
    for (int i = 0; i < LT + 3; i++) cyc(0, 0, 0, 0, 1, 0);
    cur_tag = "";
    // constrained random mix
    req_h = 0;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 7) == 0) req_h = ~req_h;
      cyc(req_h, $urandom_range(0, 3) == 0, $urandom_range(0, 40) == 0,
          $urandom_range(0, 2) != 0, $urandom_range(0, 4) != 0,
          $urandom_range(0, 5) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule